// File: doc/BRIEF.md
# Single-Bank Request Scheduler with Urgency Bit

This block orders the pending requests of one DRAM bank. Requests arrive with a row address and a one-bit urgency tag that marks traffic from applications that seldom touch memory. They wait in a small buffer, and each cycle the bank reports itself ready, the block grants one of them. The block does not arbitrate across banks and knows nothing about threads except the urgency tag.

The ranking has three levels. An urgent request beats any request that is not urgent. Between requests of equal urgency, one that targets the row already open in the bank beats one that does not. When both of those are equal, the request that arrived first wins. The block remembers the row left open by the last grant, so the next decision can favour hits. For every grant it reports the buffer slot, the row, and whether the grant is a row hit. Timing and command generation are left to the logic that follows the block.

Top module: `bank_req_sched`

## Requirements
- R1: After reset the buffer is empty, `sched_full` is low, no grant is issued even with `bank_ready` high, and no row is open.
- R2: `gnt_valid` is high exactly when `bank_ready` is high and at least one entry is pending. The granted entry is released at that clock edge and is never granted a second time.
- R3: If any pending entry has its urgency tag set, the grant goes to an entry whose tag is set, whatever the row-hit status or age of the others.
- R4: Among entries of equal urgency, an entry whose row equals the open row is granted before one whose row does not.
- R5: When urgency and hit status are equal, the earliest arrival is granted first.
- R6: A request accepted at a clock edge is stored in the lowest-numbered slot that was free before that edge. `gnt_idx` names that slot, and `gnt_row` returns the row stored with it.
- R7: `sched_full` is high exactly when all DEPTH slots hold pending requests. A request presented while `sched_full` is high is dropped and is never granted.
- R8: Each grant makes the granted row the open row. Until the first grant after reset, no grant counts as a row hit.
- R9: `gnt_hit` is high when a row is open and the granted entry's row equals it, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A new request is presented |
| req_row | input | ROW_W | Row address of the new request |
| req_urgent | input | 1 | Urgency tag of the new request |
| bank_ready | input | 1 | The bank can accept a command this cycle |
| sched_full | output | 1 | All slots are occupied |
| gnt_valid | output | 1 | A grant is issued this cycle |
| gnt_idx | output | $clog2(DEPTH) | Slot of the granted entry |
| gnt_row | output | ROW_W | Row of the granted entry |
| gnt_hit | output | 1 | The granted entry hits the open row |

## Verification
The bench builds the block with DEPTH = 4 and ROW_W = 4. With only four slots, a sweep over all sixteen urgency masks of a full buffer covers every combination of urgent and plain entries. Rows are drawn from a set of three values, so hits, misses and repeated rows occur often. A long pseudo-random phase then mixes inserts, grants, stalls and full-buffer rejections against an arithmetic model of the three-level ranking. In that phase the buffer repeatedly fills, drains and refills freed holes.

// File: rtl/bsched_pkg.sv
// Package: shared defaults and the rank type used by the bank scheduler.
// Assumes nothing beyond IEEE 1800-2017.
package bsched_pkg;
    localparam int unsigned DEF_DEPTH = 8;
    localparam int unsigned DEF_ROW_W = 14;

    // Class of a pending request; a higher packed value ranks higher.
    typedef struct packed {
        logic urgent;
        logic hit;
    } rank_t;
endpackage

// File: rtl/bsched_buf.sv
// Request buffer: DEPTH slots, each holding row, urgency tag and an arrival
// rank. Ages are kept dense (0 .. occupancy-1, 0 = oldest), so they never wrap.
// Assumes free_idx names a valid slot whenever free_en is high.
module bsched_buf #(
    parameter int unsigned DEPTH = bsched_pkg::DEF_DEPTH,
    parameter int unsigned ROW_W = bsched_pkg::DEF_ROW_W,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ins_en,
    input  logic [ROW_W-1:0]             ins_row,
    input  logic                         ins_urgent,
    input  logic                         free_en,
    input  logic [IDX_W-1:0]             free_idx,
    output logic [DEPTH-1:0]             slot_valid,
    output logic [DEPTH-1:0][ROW_W-1:0]  slot_row,
    output logic [DEPTH-1:0]             slot_urgent,
    output logic [DEPTH-1:0][IDX_W-1:0]  slot_age,
    output logic                         full
);
    logic [IDX_W-1:0] ins_slot;
    logic [CNT_W-1:0] occupancy;
    logic [IDX_W-1:0] new_age;
    logic [IDX_W-1:0] freed_age;
    logic             ins_fire;

    // Pick the lowest free slot and count occupied slots.
    always_comb begin
        ins_slot  = '0;
        occupancy = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!slot_valid[i]) ins_slot = IDX_W'(i);
            else                occupancy = occupancy + 1'b1;
        end
    end

    assign full      = &slot_valid;
    assign ins_fire  = ins_en && !full;
    assign freed_age = slot_age[free_idx];
    assign new_age   = IDX_W'(occupancy - CNT_W'(free_en));

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Per-slot state: load on insert, clear on release, close age gaps.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_valid[g]  <= 1'b0;
                slot_row[g]    <= '0;
                slot_urgent[g] <= 1'b0;
                slot_age[g]    <= '0;
            end else if (ins_fire && ins_slot == IDX_W'(g)) begin
                slot_valid[g]  <= 1'b1;
                slot_row[g]    <= ins_row;
                slot_urgent[g] <= ins_urgent;
                slot_age[g]    <= new_age;
            end else if (free_en && free_idx == IDX_W'(g)) begin
                slot_valid[g]  <= 1'b0;
            end else if (free_en && slot_valid[g] && slot_age[g] > freed_age) begin
                slot_age[g]    <= slot_age[g] - 1'b1;
            end
        end
    end
endmodule

// File: rtl/bsched_pick.sv
// Arbiter: selects the best valid slot by urgency, then row hit, then age
// (smaller is older); an exact tie keeps the lower index. Pure logic.
module bsched_pick #(
    parameter int unsigned DEPTH = bsched_pkg::DEF_DEPTH,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]            cand_valid,
    input  logic [DEPTH-1:0]            cand_urgent,
    input  logic [DEPTH-1:0]            cand_hit,
    input  logic [DEPTH-1:0][IDX_W-1:0] cand_age,
    output logic                        any_valid,
    output logic [IDX_W-1:0]            win_idx
);
    import bsched_pkg::*;

    rank_t            best_rank;
    rank_t            cur_rank;
    logic [IDX_W-1:0] best_age;

    // Linear scan keeping the best candidate seen so far.
    always_comb begin
        any_valid = 1'b0;
        win_idx   = '0;
        best_rank = '0;
        best_age  = '0;
        cur_rank  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            cur_rank = '{urgent: cand_urgent[i], hit: cand_hit[i]};
            if (cand_valid[i] &&
                (!any_valid || cur_rank > best_rank ||
                 (cur_rank == best_rank && cand_age[i] < best_age))) begin
                any_valid = 1'b1;
                win_idx   = IDX_W'(i);
                best_rank = cur_rank;
                best_age  = cand_age[i];
            end
        end
    end
endmodule

// File: rtl/bsched_openrow.sv
// Open-row register: remembers the row left open by the last grant.
// Cleared by reset to "no row open".
module bsched_openrow #(
    parameter int unsigned ROW_W = bsched_pkg::DEF_ROW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_en,
    input  logic [ROW_W-1:0] upd_row,
    output logic             open_valid,
    output logic [ROW_W-1:0] open_row
);
    // Capture the granted row on every grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_valid <= 1'b0;
            open_row   <= '0;
        end else if (upd_en) begin
            open_valid <= 1'b1;
            open_row   <= upd_row;
        end
    end
endmodule

// File: rtl/bank_req_sched.sv
// Top: single-bank scheduler. Buffers requests, grants one per ready cycle
// ranked urgency > row hit > age, and tracks the open row.
// Assumes DEPTH >= 2; outputs are combinational from state and bank_ready.
module bank_req_sched #(
    parameter int unsigned DEPTH = bsched_pkg::DEF_DEPTH,
    parameter int unsigned ROW_W = bsched_pkg::DEF_ROW_W,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [ROW_W-1:0] req_row,
    input  logic             req_urgent,
    input  logic             bank_ready,
    output logic             sched_full,
    output logic             gnt_valid,
    output logic [IDX_W-1:0] gnt_idx,
    output logic [ROW_W-1:0] gnt_row,
    output logic             gnt_hit
);
    logic [DEPTH-1:0]             ent_valid;
    logic [DEPTH-1:0][ROW_W-1:0]  ent_row;
    logic [DEPTH-1:0]             ent_urgent;
    logic [DEPTH-1:0][IDX_W-1:0]  ent_age;
    logic [DEPTH-1:0]             ent_hit;
    logic                         any_pending;
    logic [IDX_W-1:0]             pick_idx;
    logic                         open_valid;
    logic [ROW_W-1:0]             open_row;

    bsched_buf #(.DEPTH(DEPTH), .ROW_W(ROW_W)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .ins_en     (req_valid),
        .ins_row    (req_row),
        .ins_urgent (req_urgent),
        .free_en    (gnt_valid),
        .free_idx   (pick_idx),
        .slot_valid (ent_valid),
        .slot_row   (ent_row),
        .slot_urgent(ent_urgent),
        .slot_age   (ent_age),
        .full       (sched_full)
    );

    // Per-slot row-hit flags against the open row.
    for (genvar g = 0; g < DEPTH; g++) begin : g_hit
        assign ent_hit[g] = open_valid && (ent_row[g] == open_row);
    end

    bsched_pick #(.DEPTH(DEPTH)) u_pick (
        .cand_valid (ent_valid),
        .cand_urgent(ent_urgent),
        .cand_hit   (ent_hit),
        .cand_age   (ent_age),
        .any_valid  (any_pending),
        .win_idx    (pick_idx)
    );

    bsched_openrow #(.ROW_W(ROW_W)) u_open (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (gnt_valid),
        .upd_row   (gnt_row),
        .open_valid(open_valid),
        .open_row  (open_row)
    );

    assign gnt_valid = bank_ready && any_pending;
    assign gnt_idx   = pick_idx;
    assign gnt_row   = ent_row[pick_idx];
    assign gnt_hit   = ent_hit[pick_idx];
endmodule

// File: rtl/bank_sched_chk.sv
// Checker for bank_req_sched, attached by the bind at the end of this file.
// Observes ports plus the buffer's slot vectors.
module bank_sched_chk #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned ROW_W = 14,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bank_ready,
    input logic             gnt_valid,
    input logic [IDX_W-1:0] gnt_idx,
    input logic [ROW_W-1:0] gnt_row,
    input logic             gnt_hit,
    input logic [DEPTH-1:0] ent_valid,
    input logic [DEPTH-1:0] ent_urgent
);
    logic seen_grant;
    logic warm;

    // Track whether any grant has happened since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_grant <= 1'b0;
            warm       <= 1'b0;
        end else begin
            warm <= 1'b1;
            if (gnt_valid) seen_grant <= 1'b1;
        end
    end

    a_r2_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> bank_ready);

    a_r2_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> ent_valid[gnt_idx]);

    a_r2_no_regrant: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |=> !(gnt_valid && gnt_idx == $past(gnt_idx)));

    a_r3_urgent_first: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && (|(ent_valid & ent_urgent))) |-> ent_urgent[gnt_idx]);

    a_r8_no_hit_before_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_grant |-> !gnt_hit);

    a_r9_same_row_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(gnt_valid) && gnt_valid && gnt_row == $past(gnt_row)) |-> gnt_hit);
endmodule

bind bank_req_sched bank_sched_chk #(.DEPTH(DEPTH), .ROW_W(ROW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_ready(bank_ready),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx),
    .gnt_row   (gnt_row),
    .gnt_hit   (gnt_hit),
    .ent_valid (ent_valid),
    .ent_urgent(ent_urgent)
);

// File: tb/test_bank_req_sched.sv
// Bench: DEPTH=4, ROW_W=4; directed cases, an urgency-mask sweep and a
// pseudo-random phase, all checked against an arithmetic model.
module test_bank_req_sched;
    localparam int DEPTH = 4;
    localparam int ROW_W = 4;
    localparam int IDX_W = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic             req_urgent = 1'b0;
    logic             bank_ready = 1'b0;
    logic             sched_full;
    logic             gnt_valid;
    logic [IDX_W-1:0] gnt_idx;
    logic [ROW_W-1:0] gnt_row;
    logic             gnt_hit;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    // model state
    bit     m_v[DEPTH];
    int     m_row[DEPTH];
    bit     m_urg[DEPTH];
    int     m_seq[DEPTH];
    int     seq_ctr = 0;
    bit     m_open_v = 0;
    int     m_open = 0;
    string  idx_tag = "";

    always #4 clk = ~clk;

    bank_req_sched #(.DEPTH(DEPTH), .ROW_W(ROW_W)) i_bank_req_sched (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row),
        .req_urgent(req_urgent), .bank_ready(bank_ready), .sched_full(sched_full),
        .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .gnt_row(gnt_row), .gnt_hit(gnt_hit)
    );

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_hit(int i);
        return m_open_v && m_row[i] == m_open;
    endfunction

    // true when slot a outranks slot b
    function automatic bit beats(int a, int b);
        if (m_urg[a] != m_urg[b]) return m_urg[a];
        if (m_hit(a) != m_hit(b)) return m_hit(a);
        return m_seq[a] < m_seq[b];
    endfunction

    // One cycle: drive, check outputs against the model, update the model.
    task automatic step(bit rv, int row, bit urg, bit rdy);
        int  win, second, cnt, slot;
        string why;
        @(negedge clk);
        req_valid = rv; req_row = ROW_W'(row); req_urgent = urg; bank_ready = rdy;
        #1;
        win = -1; second = -1; cnt = 0;
        for (int i = 0; i < DEPTH; i++) if (m_v[i]) begin
            cnt++;
            if (win < 0 || beats(i, win)) begin second = win; win = i; end
            else if (second < 0 || beats(i, second)) second = i;
        end
        check("R7 full flag", int'(sched_full), int'(cnt == DEPTH));
        check("R2 grant valid", int'(gnt_valid), int'(rdy && cnt > 0));
        if (rdy && win >= 0) begin
            if (idx_tag != "") why = idx_tag;
            else if (second < 0) why = "R6 sole entry";
            else if (m_urg[win] != m_urg[second]) why = "R3 urgency";
            else if (m_hit(win) != m_hit(second)) why = "R4 row hit";
            else why = "R5 age";
            check(why, int'(gnt_idx), win);
            check("R6 grant row", int'(gnt_row), m_row[win]);
            check(m_open_v ? "R9 hit flag" : "R8 no open row", int'(gnt_hit), int'(m_hit(win)));
        end
        slot = -1;
        for (int i = DEPTH - 1; i >= 0; i--) if (!m_v[i]) slot = i;
        if (rdy && win >= 0) begin
            m_v[win] = 0; m_open_v = 1; m_open = m_row[win];
        end
        if (rv && cnt < DEPTH) begin
            m_v[slot] = 1; m_row[slot] = row; m_urg[slot] = urg; m_seq[slot] = seq_ctr++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; req_valid = 0; bank_ready = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < DEPTH; i++) m_v[i] = 0;
        m_open_v = 0;
    endtask

    task automatic drain();
        for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 0, 1);
    endtask

    initial begin
        logic [31:0] lcg = 32'h1234_5678;
        do_reset();
        // R1: reset state with bank_ready high
        @(negedge clk); bank_ready = 1; #1;
        check("R1 no grant after reset", int'(gnt_valid), 0);
        check("R1 not full after reset", int'(sched_full), 0);
        // R8: equal rows before any grant do not count as hits
        step(1, 5, 0, 0);
        step(1, 5, 0, 0);
        step(0, 0, 0, 1);            // first grant: miss
        step(0, 0, 0, 1);            // second: hit on row 5
        // R5 plain order and R6 hole refill
        idx_tag = "R5 arrival order";
        for (int i = 0; i < DEPTH; i++) step(1, 8 + i, 0, 0);
        step(1, 15, 0, 0);           // R7 dropped while full
        idx_tag = "R6 refill freed slot";
        step(1, 3, 0, 1);            // grant slot 0, insert goes to slot 1? no: slot 0 busy before edge -> dropped (full)
        step(1, 3, 0, 0);            // now inserted into freed slot
        idx_tag = "";
        drain();
        // R3/R4/R5 sweep over all urgency masks of a full buffer
        for (int mask = 0; mask < (1 << DEPTH); mask++) begin
            for (int r = 0; r < 3; r++) begin
                step(1, r, 1, 1);
                step(0, 0, 0, 1);
                for (int i = 0; i < DEPTH; i++) step(1, (i * 2 + mask + r) % 3, mask[i], 0);
                step(1, 1, 1, 0);    // R7 dropped
                drain();
            end
        end
        // pseudo-random mix
        for (int c = 0; c < 6000; c++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            step(lcg[16], int'(lcg[19:18]) % 3, lcg[21], lcg[24] | lcg[25]);
        end
        drain();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule